// File: doc/BRIEF.md
# Memory Protection Access Checker

This block judges each bus-master access, in the cycle it is presented, against eight programmable address-range descriptors and two fixed rules. Each access carries a master number, a supervisor/user bit, a 23-bit address and a type (read, write or instruction fetch). The checker answers at once with a grant or a violation. A violation sets a sticky error flag and freezes a record of the failing address and master. If the primary CPU made the illegal access, the checker also raises an interrupt request that cannot be masked locally.

Software programs the descriptors through a small register port. It clears the error flag by writing a one to the status register. The interrupt request ignores that clear. It drops only when the CPU's vector fetch is signalled on a separate acknowledge input, so the flag can remain set after the request has gone away.

A descriptor cannot override the fixed rules. The CPU may always read and write the page-register window. The other masters may never read or write that window. While the error flag is set, the CPU in supervisor mode may also read and write the peripheral space, so that it can always reach the status register to clear the flag.

Top module: `mpu_access_check`

## Requirements
- R1: A synchronous active-high reset makes every register read back as zero and drives `irq_req` low. After reset, any access that no fixed rule grants is a violation.
- R2: While `acc_valid` is high, exactly one of `acc_ok` and `acc_viol` is high in the same cycle. While `acc_valid` is low, both are low. An access is granted when some descriptor covers the address (lower and upper bounds both inclusive), has the enable bit set for the master, and allows the type. Masters: 0 is the CPU, 1 the secondary master, 2 the third master. Types: 0 read, 1 write, 2 or 3 fetch.
- R3: A descriptor with its write-protect bit set (bit 28 of its upper register) refuses writes. It still grants reads and fetches.
- R4: A descriptor with its no-execute bit set (bit 29 of its upper register) refuses both fetch codes. It still grants reads.
- R5: Master 0 may always read and write addresses 0x0010 to 0x0017, even with no descriptor programmed.
- R6: Masters other than 0 are always refused reads and writes inside 0x0010 to 0x0017, even when a descriptor grants them. Fetches there, and accesses at 0x000F and 0x0018, follow the descriptors.
- R7: While the error flag is set, master 0 in supervisor mode may read and write any address from 0 to 0x07FF. This does not apply in user mode, above 0x07FF, or while the flag is clear.
- R8: A violation sets the error flag at the next clock edge. The status register (address 0) holds the flag in bit 0, the master in bits 2:1 and the address in bits 30:8. The first violation is recorded, and later violations leave the record unchanged while the flag stays set.
- R9: Writing a status word with bit 0 set clears the flag at the next edge. A write with bit 0 clear has no effect. If a violation arrives in the same cycle as a clear, the flag stays set and the new access is recorded.
- R10: A violation by master 0 raises `irq_req` at the next edge. Violations by other masters set the flag but leave `irq_req` unchanged.
- R11: Once raised, `irq_req` stays high until `vec_ack` is sampled high at an edge, and falls at that edge. Clearing the error flag does not lower it, and the acknowledge does not clear the flag.
- R12: Descriptor k (k = 0..7) has its lower bound at register 2k+1, bits 22:0. Its upper register is 2k+2: upper bound in bits 22:0, master enables in bits 26:24 (bit 24 + master), write-protect in bit 28, no-execute in bit 29. Reads return the stored fields, with zeros in every unused bit. `reg_rdata` follows `reg_addr` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_mst | input | 2 | Master number: 0 CPU, 1 secondary, 2 third |
| acc_sup | input | 1 | Access made in supervisor mode |
| acc_kind | input | 2 | 0 read, 1 write, 2 or 3 fetch |
| acc_addr | input | 23 | Access address |
| acc_ok | output | 1 | Access granted (combinational) |
| acc_viol | output | 1 | Access refused (combinational) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register index: 0 status, 1..16 descriptors |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq_req | output | 1 | Access-error interrupt request to the CPU |
| vec_ack | input | 1 | CPU interrupt vector fetch observed |

## Verification
A corrupted descriptor field shows at `acc_ok`/`acc_viol` in the same cycle as the first access that lands in the damaged range. The same fault also appears at once in the register readback. A wrong error-flag or capture state shows one cycle after the triggering access, in three ways: a changed status word, a peripheral access granted or refused in the wrong mode (the supervisor rule), or a record that moves while it should stay frozen. A wrong interrupt state shows on `irq_req` one edge after a CPU violation or an acknowledge, and it stays wrong until the next acknowledge.

// File: rtl/mpu_pkg.sv
package mpu_pkg;
    localparam int ADDR_W  = 23;
    localparam int NUM_MST = 3;
    localparam int MID_W   = 2;
    localparam int DATA_W  = 32;

    // Register field positions
    localparam int EN_LSB  = 24;
    localparam int WP_BIT  = 28;
    localparam int NX_BIT  = 29;
    localparam int CAP_LSB = 8;
    localparam int CAPM_LSB = 1;

    localparam logic [MID_W-1:0] MST_CPU = '0;
    localparam logic [1:0]       KIND_WR = 2'd1;

    typedef struct packed {
        logic [ADDR_W-1:0]  lo;
        logic [ADDR_W-1:0]  hi;
        logic [NUM_MST-1:0] en;
        logic               wp;
        logic               nx;
    } desc_t;
endpackage

// File: rtl/mpu_desc_match.sv
module mpu_desc_match
    import mpu_pkg::*;
(
    input  desc_t              desc,
    input  logic [MID_W-1:0]   mst,
    input  logic [1:0]         kind,
    input  logic [ADDR_W-1:0]  addr,
    output logic               grant
);
    logic in_rng;
    logic mst_en;
    logic is_wr;
    logic is_fetch;

    always_comb begin
        in_rng   = (addr >= desc.lo) && (addr <= desc.hi);
        mst_en   = 1'b0;
        for (int i = 0; i < NUM_MST; i++) begin
            if (mst == MID_W'(i)) mst_en = desc.en[i];
        end
        is_wr    = (kind == KIND_WR);
        is_fetch = kind[1];
        grant    = in_rng && mst_en && !(is_wr && desc.wp) && !(is_fetch && desc.nx);
    end
endmodule

// File: rtl/mpu_fixed_rules.sv
module mpu_fixed_rules
    import mpu_pkg::*;
#(
    parameter logic [ADDR_W-1:0] PAGE_LO = 23'h10,
    parameter logic [ADDR_W-1:0] PAGE_HI = 23'h17,
    parameter logic [ADDR_W-1:0] PERI_HI = 23'h7FF
) (
    input  logic [MID_W-1:0]   mst,
    input  logic               sup,
    input  logic [1:0]         kind,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               err_flag,
    output logic               force_ok,
    output logic               force_deny
);
    logic is_rw;
    logic is_cpu;
    logic in_page;
    logic in_peri;

    always_comb begin
        is_rw      = !kind[1];
        is_cpu     = (mst == MST_CPU);
        in_page    = (addr >= PAGE_LO) && (addr <= PAGE_HI);
        in_peri    = (addr <= PERI_HI);
        force_ok   = is_rw && is_cpu && (in_page || (sup && err_flag && in_peri));
        force_deny = is_rw && !is_cpu && in_page;
    end
endmodule

// File: rtl/mpu_access_check.sv
module mpu_access_check
    import mpu_pkg::*;
#(
    parameter int                NUM_DESC = 8,
    parameter logic [ADDR_W-1:0] PAGE_LO  = 23'h10,
    parameter logic [ADDR_W-1:0] PAGE_HI  = 23'h17,
    parameter logic [ADDR_W-1:0] PERI_HI  = 23'h7FF,
    localparam int               REG_AW   = $clog2(2*NUM_DESC+1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               acc_valid,
    input  logic [MID_W-1:0]   acc_mst,
    input  logic               acc_sup,
    input  logic [1:0]         acc_kind,
    input  logic [ADDR_W-1:0]  acc_addr,
    output logic               acc_ok,
    output logic               acc_viol,
    input  logic               reg_wr,
    input  logic [REG_AW-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic               irq_req,
    input  logic               vec_ack
);
    typedef struct packed {
        desc_t [NUM_DESC-1:0] desc;
        logic                 flag;
        logic [ADDR_W-1:0]    cap_addr;
        logic [MID_W-1:0]     cap_mst;
        logic                 irq;
    } state_t;

    state_t s_d, s_q;

    logic [NUM_DESC-1:0] hit;
    logic                force_ok;
    logic                force_deny;
    logic                legal;
    logic                clr_req;
    logic                err_flag;
    logic [ADDR_W-1:0]   cap_addr;

    assign err_flag = s_q.flag;
    assign cap_addr = s_q.cap_addr;

    // One range matcher per descriptor
    for (genvar g = 0; g < NUM_DESC; g++) begin : g_desc
        mpu_desc_match u_match (
            .desc  (s_q.desc[g]),
            .mst   (acc_mst),
            .kind  (acc_kind),
            .addr  (acc_addr),
            .grant (hit[g])
        );
    end

    mpu_fixed_rules #(
        .PAGE_LO (PAGE_LO),
        .PAGE_HI (PAGE_HI),
        .PERI_HI (PERI_HI)
    ) u_fixed (
        .mst        (acc_mst),
        .sup        (acc_sup),
        .kind       (acc_kind),
        .addr       (acc_addr),
        .err_flag   (s_q.flag),
        .force_ok   (force_ok),
        .force_deny (force_deny)
    );

    always_comb begin
        legal    = !force_deny && (force_ok || (|hit));
        acc_ok   = acc_valid && legal;
        acc_viol = acc_valid && !legal;
        irq_req  = s_q.irq;
    end

    always_comb begin
        s_d     = s_q;
        clr_req = reg_wr && (reg_addr == '0) && reg_wdata[0];
        if (clr_req) s_d.flag = 1'b0;

        for (int i = 0; i < NUM_DESC; i++) begin
            if (reg_wr && (reg_addr == REG_AW'(2*i+1))) begin
                s_d.desc[i].lo = reg_wdata[ADDR_W-1:0];
            end
            if (reg_wr && (reg_addr == REG_AW'(2*i+2))) begin
                s_d.desc[i].hi = reg_wdata[ADDR_W-1:0];
                s_d.desc[i].en = reg_wdata[EN_LSB +: NUM_MST];
                s_d.desc[i].wp = reg_wdata[WP_BIT];
                s_d.desc[i].nx = reg_wdata[NX_BIT];
            end
        end

        if (acc_viol) begin
            s_d.flag = 1'b1;
            if (!s_q.flag || clr_req) begin
                s_d.cap_addr = acc_addr;
                s_d.cap_mst  = acc_mst;
            end
        end

        s_d.irq = (s_q.irq && !vec_ack) || (acc_viol && (acc_mst == MST_CPU));
    end

    // Register readback
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == '0) begin
            reg_rdata[0]                   = s_q.flag;
            reg_rdata[CAPM_LSB +: MID_W]   = s_q.cap_mst;
            reg_rdata[CAP_LSB +: ADDR_W]   = s_q.cap_addr;
        end
        for (int i = 0; i < NUM_DESC; i++) begin
            if (reg_addr == REG_AW'(2*i+1)) begin
                reg_rdata[ADDR_W-1:0] = s_q.desc[i].lo;
            end
            if (reg_addr == REG_AW'(2*i+2)) begin
                reg_rdata[ADDR_W-1:0]         = s_q.desc[i].hi;
                reg_rdata[EN_LSB +: NUM_MST]  = s_q.desc[i].en;
                reg_rdata[WP_BIT]             = s_q.desc[i].wp;
                reg_rdata[NX_BIT]             = s_q.desc[i].nx;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end
endmodule

// File: rtl/mpu_access_check_chk.sv
module mpu_access_check_chk
    import mpu_pkg::*;
#(
    parameter logic [ADDR_W-1:0] PAGE_LO = 23'h10,
    parameter logic [ADDR_W-1:0] PAGE_HI = 23'h17,
    parameter int                REG_AW  = 5
) (
    input logic               clk,
    input logic               rst,
    input logic               acc_valid,
    input logic [MID_W-1:0]   acc_mst,
    input logic [1:0]         acc_kind,
    input logic [ADDR_W-1:0]  acc_addr,
    input logic               acc_ok,
    input logic               acc_viol,
    input logic               reg_wr,
    input logic [REG_AW-1:0]  reg_addr,
    input logic [DATA_W-1:0]  reg_wdata,
    input logic               irq_req,
    input logic               vec_ack,
    input logic               err_flag,
    input logic [ADDR_W-1:0]  cap_addr
);
    logic in_page;
    logic cpu_viol;
    logic clr_wr;

    always_comb begin
        in_page  = (acc_addr >= PAGE_LO) && (acc_addr <= PAGE_HI);
        cpu_viol = acc_viol && (acc_mst == MST_CPU);
        clr_wr   = reg_wr && (reg_addr == '0) && reg_wdata[0];
    end

    AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (rst)
        acc_valid |-> (acc_ok != acc_viol));                                   // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |-> (!acc_ok && !acc_viol));                                // R2
    AST_PAGE_CPU_RW: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_mst == MST_CPU && !acc_kind[1] && in_page) |-> acc_ok); // R5
    AST_PAGE_OTHER_DENY: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_mst != MST_CPU && !acc_kind[1] && in_page) |-> acc_viol); // R6
    AST_FLAG_ON_VIOL: assert property (@(posedge clk) disable iff (rst)
        acc_viol |=> err_flag);                                                // R8
    AST_CAPTURE_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (err_flag && !clr_wr) |=> $stable(cap_addr));                          // R8
    AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (clr_wr && !acc_viol) |=> !err_flag);                                  // R9
    AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (rst)
        cpu_viol |=> irq_req);                                                 // R10
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!irq_req && !cpu_viol) |=> !irq_req);                                 // R10
    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (irq_req && !vec_ack) |=> irq_req);                                    // R11
    AST_IRQ_ACK_DROP: assert property (@(posedge clk) disable iff (rst)
        (irq_req && vec_ack && !cpu_viol) |=> !irq_req);                       // R11
endmodule

bind mpu_access_check mpu_access_check_chk #(
    .PAGE_LO (PAGE_LO),
    .PAGE_HI (PAGE_HI),
    .REG_AW  (REG_AW)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .acc_valid (acc_valid),
    .acc_mst   (acc_mst),
    .acc_kind  (acc_kind),
    .acc_addr  (acc_addr),
    .acc_ok    (acc_ok),
    .acc_viol  (acc_viol),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .irq_req   (irq_req),
    .vec_ack   (vec_ack),
    .err_flag  (err_flag),
    .cap_addr  (cap_addr)
);

// File: tb/tb_mpu_access_check.sv
`timescale 1ns/1ps
module tb_mpu_access_check;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_valid = 1'b0;
    logic [1:0]  acc_mst = '0;
    logic        acc_sup = 1'b0;
    logic [1:0]  acc_kind = '0;
    logic [22:0] acc_addr = '0;
    logic        acc_ok, acc_viol;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_req;
    logic        vec_ack = 1'b0;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    mpu_access_check dut (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_mst(acc_mst),
        .acc_sup(acc_sup), .acc_kind(acc_kind), .acc_addr(acc_addr),
        .acc_ok(acc_ok), .acc_viol(acc_viol), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_req(irq_req), .vec_ack(vec_ack)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic [1:0]  m;
        logic        s;
        logic [1:0]  k;
        logic [22:0] a;
        logic        e;
    } vec_t;

    // req, master, supervisor, kind, address, expected grant
    localparam int NVEC = 19;
    localparam vec_t VEC [NVEC] = '{
        '{4'd2, 2'd0, 1'b1, 2'd0, 23'h1000, 1'b1},   // R2 lower bound
        '{4'd2, 2'd0, 1'b1, 2'd1, 23'h1FFF, 1'b1},   // R2 upper bound
        '{4'd2, 2'd0, 1'b0, 2'd2, 23'h1800, 1'b1},   // R2 fetch
        '{4'd3, 2'd0, 1'b1, 2'd0, 23'h2000, 1'b1},   // R3 read in protected range
        '{4'd3, 2'd0, 1'b0, 2'd1, 23'h2000, 1'b0},   // R3 write refused
        '{4'd3, 2'd1, 1'b0, 2'd1, 23'h2ABC, 1'b0},   // R3
        '{4'd3, 2'd1, 1'b0, 2'd2, 23'h2800, 1'b1},   // R3 fetch still allowed
        '{4'd4, 2'd1, 1'b0, 2'd2, 23'h3000, 1'b0},   // R4
        '{4'd4, 2'd1, 1'b0, 2'd3, 23'h3FFF, 1'b0},   // R4 second fetch code
        '{4'd4, 2'd1, 1'b0, 2'd0, 23'h3FFF, 1'b1},   // R4 read ok
        '{4'd2, 2'd2, 1'b0, 2'd0, 23'h3500, 1'b0},   // R2 master not enabled
        '{4'd2, 2'd0, 1'b0, 2'd0, 23'h4000, 1'b0},   // R2 uncovered
        '{4'd2, 2'd0, 1'b0, 2'd0, 23'h0FFF, 1'b0},   // R2 just below range
        '{4'd6, 2'd1, 1'b0, 2'd1, 23'h0013, 1'b0},   // R6
        '{4'd6, 2'd2, 1'b0, 2'd0, 23'h0017, 1'b0},   // R6
        '{4'd6, 2'd1, 1'b0, 2'd0, 23'h0018, 1'b1},   // R6 edge above window
        '{4'd6, 2'd1, 1'b0, 2'd1, 23'h000F, 1'b1},   // R6 edge below window
        '{4'd6, 2'd1, 1'b0, 2'd2, 23'h0014, 1'b1},   // R6 fetch not blocked
        '{4'd5, 2'd0, 1'b0, 2'd2, 23'h0010, 1'b1}    // R5 fetch by descriptor
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input logic [1:0] m, input logic s, input logic [1:0] k,
                          input logic [22:0] a, input logic e, input string req);
        @(negedge clk);
        acc_mst = m; acc_sup = s; acc_kind = k; acc_addr = a; acc_valid = 1'b1;
        #1;
        chk(req, {30'd0, acc_ok, acc_viol}, e ? 32'd2 : 32'd1);
        @(posedge clk);
        #1;
        acc_valid = 1'b0;
    endtask

    task automatic wr_reg(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [4:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(req, reg_rdata, exp);
    endtask

    task automatic ack();
        @(negedge clk);
        vec_ack = 1'b1;
        @(posedge clk);
        #1;
        vec_ack = 1'b0;
    endtask

    function automatic logic [31:0] stat(input logic [22:0] a, input logic [1:0] m, input logic f);
        return {1'b0, a, 5'd0, m, f};
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        for (int i = 0; i < 17; i++) rd_chk(5'(i), 32'd0, "R1 register reset");
        chk("R1 irq reset", {31'd0, irq_req}, 32'd0);
        chk("R2 idle verdicts", {30'd0, acc_ok, acc_viol}, 32'd0);
        access(2'd0, 1'b0, 2'd0, 23'h1000, 1'b0, "R1 no descriptor");
        rd_chk(5'd0, stat(23'h1000, 2'd0, 1'b1), "R8 first capture");
        chk("R10 irq after cpu violation", {31'd0, irq_req}, 32'd1);

        // R5 page window for the CPU with no descriptors
        access(2'd0, 1'b0, 2'd1, 23'h0010, 1'b1, "R5 write");
        access(2'd0, 1'b1, 2'd0, 23'h0017, 1'b1, "R5 read");
        access(2'd0, 1'b0, 2'd0, 23'h0018, 1'b0, "R5 outside window");
        // R6 other masters
        access(2'd1, 1'b1, 2'd0, 23'h0012, 1'b0, "R6 secondary read");
        rd_chk(5'd0, stat(23'h1000, 2'd0, 1'b1), "R8 capture frozen");

        // R11 acknowledge drops irq, flag stays
        ack();
        chk("R11 irq after ack", {31'd0, irq_req}, 32'd0);
        rd_chk(5'd0, stat(23'h1000, 2'd0, 1'b1), "R11 flag kept");

        // R7 supervisor peripheral access while flag set
        access(2'd0, 1'b1, 2'd1, 23'h0400, 1'b1, "R7 supervisor write");
        access(2'd0, 1'b1, 2'd0, 23'h07FF, 1'b1, "R7 top of space");
        access(2'd0, 1'b1, 2'd0, 23'h0800, 1'b0, "R7 above space");
        access(2'd0, 1'b0, 2'd0, 23'h0400, 1'b0, "R7 user mode");

        // R9 write of zero leaves flag, write of one clears it
        wr_reg(5'd0, 32'hFFFF_FFFE);
        rd_chk(5'd0, stat(23'h1000, 2'd0, 1'b1), "R9 zero write ignored");
        wr_reg(5'd0, 32'd1);
        rd_chk(5'd0, stat(23'h1000, 2'd0, 1'b0), "R9 flag cleared");
        chk("R11 irq survives flag clear", {31'd0, irq_req}, 32'd1);
        access(2'd0, 1'b1, 2'd0, 23'h0400, 1'b0, "R7 flag clear");
        rd_chk(5'd0, stat(23'h0400, 2'd0, 1'b1), "R8 new capture");
        ack();
        wr_reg(5'd0, 32'd1);

        // R10 secondary violation: flag only
        access(2'd1, 1'b0, 2'd0, 23'h5000, 1'b0, "R10 secondary");
        chk("R10 no irq for secondary", {31'd0, irq_req}, 32'd0);
        rd_chk(5'd0, stat(23'h5000, 2'd1, 1'b1), "R10 flag set");

        // R9 clear and violation in the same cycle
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 5'd0; reg_wdata = 32'd1;
        acc_mst = 2'd2; acc_sup = 1'b0; acc_kind = 2'd0; acc_addr = 23'h6000; acc_valid = 1'b1;
        @(posedge clk);
        #1;
        reg_wr = 1'b0; acc_valid = 1'b0;
        rd_chk(5'd0, stat(23'h6000, 2'd2, 1'b1), "R9 violation wins");
        wr_reg(5'd0, 32'd1);

        // R12 readback and descriptor programming
        wr_reg(5'd8, 32'hC880_00FF);
        rd_chk(5'd8, 32'h0000_00FF, "R12 unused bits dropped");
        wr_reg(5'd7, 32'hFF80_0000);
        rd_chk(5'd7, 32'd0, "R12 lower bound width");
        wr_reg(5'd1, 32'h0000_1000); wr_reg(5'd2, 32'h0100_1FFF);
        wr_reg(5'd3, 32'h0000_2000); wr_reg(5'd4, 32'h1700_2FFF);
        wr_reg(5'd5, 32'h0000_3000); wr_reg(5'd6, 32'h2300_3FFF);
        wr_reg(5'd8, 32'h0700_00FF);
        rd_chk(5'd4, 32'h1700_2FFF, "R12 upper with write-protect");
        rd_chk(5'd6, 32'h2300_3FFF, "R12 upper with no-execute");
        rd_chk(5'd3, 32'h0000_2000, "R12 lower");

        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            access(VEC[i].m, VEC[i].s, VEC[i].k, VEC[i].a, VEC[i].e,
                   $sformatf("R%0d vector %0d", VEC[i].req, i));
        end

        ack();
        chk("R11 final ack", {31'd0, irq_req}, 32'd0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule